// File: doc/BRIEF.md
# Programmable Divider Bank with Crosspoint

This block turns one fast clock into six derived outputs. Two independent divider banks each run a programmable divide-by-N counter. Each bank also derives two fixed-ratio taps from that same counter. Bank A has divide-by-2 and divide-by-3 taps. Bank B has divide-by-2 and divide-by-4 taps. A crosspoint gives every output its own 3-bit source code. The code picks one of the four fixed taps, one of the two divide-by-N phases, or the undivided reference. Since everything runs in the one clock domain, the undivided reference shows up as an enable that is high every cycle. Every output is registered, so it is free of glitches.

A fixed tap only stays aligned with its bank's counter period when the divisor suits it. The block therefore checks each selection against its bank's divisor rule. A selection that breaks the rule forces its output low and latches a sticky per-output error. A divisor write that falls outside the legal range is flagged and never loaded. A legal write is parked and only takes over at the end of the current count period, so no output ever sees a shortened pulse.

Top module: `clkdiv_xbar`

## Requirements
- R1: A divisor write with a value below 4 or above 127 sets that bank's bit in `n_err` (bit 0 bank A, bit 1 bank B) on the next cycle and is never loaded. A later in-range write clears the bit.
- R2: While `rst` is high at a clock edge, the following all happen: both divisors become 8, both counters go to 0, every output's source code becomes 0 (reference), and `clk_out`, `out_err` and `n_err` become zero.
- R3: A parked divisor becomes active only at the bank's terminal count, which is counter value N-1. The next period then runs with the new N.
- R4: A divide-by-N phase is high for floor(N/2) cycles, then low for ceil(N/2) cycles, with a period of N cycles. Each output register adds one cycle of latency after the counter.
- R5: The source codes are: 0 reference (constant high), 1 bank A /N, 2 bank A /2, 3 bank A /3, 4 bank B /N, 5 bank B /2, 6 bank B /4. Code 7 drives the output low and flags no error.
- R6: A fixed tap of ratio d is high while (counter mod d) < floor(d/2). The tap rules are:
  - bank A /2 needs N_A to be a multiple of 4;
  - bank A /3 needs N_A = 6;
  - bank B /2 needs N_B to be a multiple of 4;
  - bank B /4 needs N_B to be a multiple of 8.
- R7: An output whose code selects a tap that breaks its rule is driven low on the next cycle and sets its `out_err` bit. That bit stays set until reset.
- R8: The two banks' divisors, counters and parked values are independent of each other.
- R9: With `sel_we` high, `sel_code` is loaded into the output numbered by `sel_idx` (0 to 5) and steers that output from the cycle after. Indices 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, the only clock domain |
| rst | input | 1 | Synchronous active-high reset |
| na_we | input | 1 | Write strobe for bank A divisor |
| na_val | input | 7 | Bank A divisor value |
| nb_we | input | 1 | Write strobe for bank B divisor |
| nb_val | input | 7 | Bank B divisor value |
| sel_we | input | 1 | Write strobe for one output's source code |
| sel_idx | input | 3 | Output index for the source code write |
| sel_code | input | 3 | Source code (R5 encoding) |
| clk_out | output | 6 | Registered divided outputs |
| out_err | output | 6 | Sticky illegal-selection flags per output |
| n_err | output | 2 | Out-of-range divisor flags per bank |

## Verification
The bench sweeps every legal divisor from 4 to 127 on bank A. Bank B runs at the mirrored value at the same time, and all six taps are steered to the outputs. A design that handled odd N or the terminal count wrongly would then show a duty or period mismatch. A rule test on the parked divisor instead of the active one would set the errors too early. Directed cases cover several situations:
- a write in the middle of a period, which must not cut the running pulse short;
- out-of-range writes, which must leave the old period intact;
- a cleared illegal selection, whose error must stay latched;
- source code 7 and out-of-range output indices, neither of which may disturb anything.

Explicit high-cycle counts for N = 7, 9 and 10 catch a design that rounded the high phase up.

// File: rtl/clkdiv_xbar_pkg.sv
package clkdiv_xbar_pkg;

  typedef enum logic [2:0] {
    SRC_REF  = 3'd0,
    SRC_A_N  = 3'd1,
    SRC_A_T2 = 3'd2,
    SRC_A_T3 = 3'd3,
    SRC_B_N  = 3'd4,
    SRC_B_T2 = 3'd5,
    SRC_B_T4 = 3'd6,
    SRC_OFF  = 3'd7
  } src_e;

  // divisor legality window
  function automatic logic div_in_range(input int unsigned n,
                                        input int unsigned lo,
                                        input int unsigned hi);
    return (n >= lo) && (n <= hi);
  endfunction

  // high phase of a fixed tap of ratio d taken from a shared counter
  function automatic logic tap_phase(input int unsigned cnt, input int unsigned d);
    return (cnt % d) < (d / 2);
  endfunction

  // high phase of the full-period output: floor(n/2) high cycles
  function automatic logic full_phase(input int unsigned cnt, input int unsigned n);
    return cnt < (n / 2);
  endfunction

  // a tap of ratio d stays aligned if n is a multiple of 2d, or exactly 2d
  function automatic logic tap_rule(input int unsigned n, input int unsigned d,
                                    input bit exact);
    return exact ? (n == 2 * d) : ((n % (2 * d)) == 0);
  endfunction

endpackage

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
  import clkdiv_xbar_pkg::*;
#(
  parameter int NW         = 7,
  parameter int N_MIN      = 4,
  parameter int N_MAX      = 127,
  parameter int N_RST      = 8,
  parameter int TAP0_DIV   = 2,
  parameter bit TAP0_EXACT = 1'b0,
  parameter int TAP1_DIV   = 3,
  parameter bit TAP1_EXACT = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [NW-1:0] wr_n,
  output logic          full_out,
  output logic [1:0]    tap_out,
  output logic [1:0]    tap_ok,
  output logic          term,
  output logic          range_err,
  output logic [NW-1:0] n_act,
  output logic [NW-1:0] cnt
);
  localparam logic [NW-1:0] RST_V = NW'(N_RST);
  localparam logic [NW-1:0] ONE_V = NW'(1);

  logic [NW-1:0] cnt_q, n_q, pend_q;
  logic          pend_ok_q;

  assign term = (cnt_q == (n_q - ONE_V));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      n_q       <= RST_V;
      pend_q    <= RST_V;
      pend_ok_q <= 1'b1;
    end else begin
      cnt_q <= term ? '0 : cnt_q + ONE_V;
      if (term && pend_ok_q) n_q <= pend_q;
      if (wr) begin
        pend_q    <= wr_n;
        pend_ok_q <= div_in_range(32'(wr_n), N_MIN, N_MAX);
      end
    end
  end

  assign full_out  = full_phase(32'(cnt_q), 32'(n_q));
  assign range_err = ~pend_ok_q;
  assign n_act     = n_q;
  assign cnt       = cnt_q;

  for (genvar t = 0; t < 2; t++) begin : g_tap
    localparam int D  = (t == 0) ? TAP0_DIV : TAP1_DIV;
    localparam bit EX = (t == 0) ? TAP0_EXACT : TAP1_EXACT;
    assign tap_out[t] = tap_phase(32'(cnt_q), D);
    assign tap_ok[t]  = tap_rule(32'(n_q), D, EX);
  end

endmodule

// File: rtl/clkdiv_xcell.sv
module clkdiv_xcell
  import clkdiv_xbar_pkg::*;
#(
  parameter int NSRC = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sel_we,
  input  logic [2:0]      sel_code,
  input  logic [NSRC-1:0] src_val,
  input  logic [NSRC-1:0] src_ok,
  output logic            out,
  output logic            err,
  output logic [2:0]      sel,
  output logic            bad
);
  logic [2:0] sel_q;
  logic       pick_val, pick_ok;

  always_comb begin
    pick_val = 1'b0;
    pick_ok  = 1'b1;
    for (int s = 0; s < NSRC; s++) begin
      if (sel_q == 3'(s)) begin
        pick_val = src_val[s];
        pick_ok  = src_ok[s];
      end
    end
  end

  assign bad = ~pick_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 3'(SRC_REF);
      out   <= 1'b0;
      err   <= 1'b0;
    end else begin
      if (sel_we) sel_q <= sel_code;
      out <= pick_val & pick_ok;
      err <= err | bad;
    end
  end

  assign sel = sel_q;

endmodule

// File: rtl/clkdiv_xbar.sv
module clkdiv_xbar
  import clkdiv_xbar_pkg::*;
#(
  parameter int NW      = 7,
  parameter int N_MIN   = 4,
  parameter int N_MAX   = 127,
  parameter int N_RST   = 8,
  parameter int NUM_OUT = 6,
  parameter int IDXW    = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               na_we,
  input  logic [NW-1:0]      na_val,
  input  logic               nb_we,
  input  logic [NW-1:0]      nb_val,
  input  logic               sel_we,
  input  logic [IDXW-1:0]    sel_idx,
  input  logic [2:0]         sel_code,
  output logic [NUM_OUT-1:0] clk_out,
  output logic [NUM_OUT-1:0] out_err,
  output logic [1:0]         n_err
);
  localparam int NSRC = 7;

  logic          a_full, b_full;
  logic [1:0]    a_tap, b_tap, a_ok, b_ok;
  logic          a_term, b_term;
  logic [NW-1:0] a_n, b_n, a_cnt, b_cnt;
  logic [NSRC-1:0] src_val, src_ok;
  logic [3*NUM_OUT-1:0] sel_flat;
  logic [NUM_OUT-1:0]   bad;

  clkdiv_bank #(.NW(NW), .N_MIN(N_MIN), .N_MAX(N_MAX), .N_RST(N_RST),
                .TAP0_DIV(2), .TAP0_EXACT(1'b0), .TAP1_DIV(3), .TAP1_EXACT(1'b1))
  u_bank_a (
    .clk(clk), .rst(rst), .wr(na_we), .wr_n(na_val),
    .full_out(a_full), .tap_out(a_tap), .tap_ok(a_ok), .term(a_term),
    .range_err(n_err[0]), .n_act(a_n), .cnt(a_cnt)
  );

  clkdiv_bank #(.NW(NW), .N_MIN(N_MIN), .N_MAX(N_MAX), .N_RST(N_RST),
                .TAP0_DIV(2), .TAP0_EXACT(1'b0), .TAP1_DIV(4), .TAP1_EXACT(1'b0))
  u_bank_b (
    .clk(clk), .rst(rst), .wr(nb_we), .wr_n(nb_val),
    .full_out(b_full), .tap_out(b_tap), .tap_ok(b_ok), .term(b_term),
    .range_err(n_err[1]), .n_act(b_n), .cnt(b_cnt)
  );

  // source order follows the src_e encoding
  assign src_val = {b_tap[1], b_tap[0], b_full, a_tap[1], a_tap[0], a_full, 1'b1};
  assign src_ok  = {b_ok[1],  b_ok[0],  1'b1,   a_ok[1],  a_ok[0],  1'b1,   1'b1};

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    clkdiv_xcell #(.NSRC(NSRC)) u_cell (
      .clk(clk), .rst(rst),
      .sel_we(sel_we && (sel_idx == IDXW'(i))),
      .sel_code(sel_code),
      .src_val(src_val), .src_ok(src_ok),
      .out(clk_out[i]), .err(out_err[i]),
      .sel(sel_flat[3*i +: 3]), .bad(bad[i])
    );
  end

endmodule

// File: rtl/clkdiv_xbar_chk.sv
module clkdiv_xbar_chk #(
  parameter int NW      = 7,
  parameter int N_MIN   = 4,
  parameter int N_MAX   = 127,
  parameter int N_RST   = 8,
  parameter int NUM_OUT = 6
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 na_we,
  input logic [NW-1:0]        na_val,
  input logic                 nb_we,
  input logic [NW-1:0]        nb_val,
  input logic [NUM_OUT-1:0]   clk_out,
  input logic [NUM_OUT-1:0]   out_err,
  input logic [1:0]           n_err,
  input logic                 a_term,
  input logic                 b_term,
  input logic [NW-1:0]        a_n,
  input logic [NW-1:0]        b_n,
  input logic [NW-1:0]        a_cnt,
  input logic [NW-1:0]        b_cnt,
  input logic [3*NUM_OUT-1:0] sel_flat,
  input logic [NUM_OUT-1:0]   bad
);
  localparam logic [NW-1:0] LO = NW'(N_MIN);
  localparam logic [NW-1:0] HI = NW'(N_MAX);
  localparam logic [NW-1:0] RV = NW'(N_RST);

  a_r1_range_flag_a: assert property (@(posedge clk) disable iff (rst)
    na_we |=> (n_err[0] == (($past(na_val) < LO) || ($past(na_val) > HI))));
  a_r1_range_flag_b: assert property (@(posedge clk) disable iff (rst)
    nb_we |=> (n_err[1] == (($past(nb_val) < LO) || ($past(nb_val) > HI))));

  a_r2_reset_state: assert property (@(posedge clk)
    rst |=> (a_n == RV && b_n == RV && a_cnt == '0 && b_cnt == '0 &&
             sel_flat == '0 && clk_out == '0 && out_err == '0 && n_err == '0));

  a_r3_hold_a: assert property (@(posedge clk) disable iff (rst)
    !a_term |=> $stable(a_n));
  a_r3_hold_b: assert property (@(posedge clk) disable iff (rst)
    !b_term |=> $stable(b_n));

  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    (a_cnt < a_n) && (b_cnt < b_n));

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_o
    a_r7_bad_low: assert property (@(posedge clk) disable iff (rst)
      bad[i] |=> (!clk_out[i] && out_err[i]));
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
      out_err[i] |=> out_err[i]);
    a_r5_off_low: assert property (@(posedge clk) disable iff (rst)
      (sel_flat[3*i +: 3] == 3'd7) |=> !clk_out[i]);
  end

endmodule

bind clkdiv_xbar clkdiv_xbar_chk #(.NW(NW), .N_MIN(N_MIN), .N_MAX(N_MAX),
                                   .N_RST(N_RST), .NUM_OUT(NUM_OUT)) u_chk (
  .clk(clk), .rst(rst), .na_we(na_we), .na_val(na_val), .nb_we(nb_we),
  .nb_val(nb_val), .clk_out(clk_out), .out_err(out_err), .n_err(n_err),
  .a_term(a_term), .b_term(b_term), .a_n(a_n), .b_n(b_n), .a_cnt(a_cnt),
  .b_cnt(b_cnt), .sel_flat(sel_flat), .bad(bad)
);

// File: tb/tb_clkdiv_xbar.sv
module tb_clkdiv_xbar;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic na_we = 1'b0, nb_we = 1'b0, sel_we = 1'b0;
  logic [6:0] na_val = '0, nb_val = '0;
  logic [2:0] sel_idx = '0, sel_code = '0;
  logic [5:0] clk_out, out_err;
  logic [1:0] n_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkdiv_xbar dut (
    .clk(clk), .rst(rst), .na_we(na_we), .na_val(na_val), .nb_we(nb_we),
    .nb_val(nb_val), .sel_we(sel_we), .sel_idx(sel_idx), .sel_code(sel_code),
    .clk_out(clk_out), .out_err(out_err), .n_err(n_err)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // bench model state
  int m_n[2], m_cnt[2], m_pend[2];
  bit m_pok[2];
  int m_sel[6];
  bit [5:0] m_out, m_err;
  bit [1:0] m_rerr;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic src_eval(input int code, output bit v, output bit ok);
    v = 1'b0; ok = 1'b1;
    case (code)
      0: v = 1'b1;
      1: v = (2 * m_cnt[0]) < m_n[0] - (m_n[0] % 2);
      2: begin v = (m_cnt[0] % 2) == 0; ok = (m_n[0] % 4) == 0; end
      3: begin v = (m_cnt[0] % 3) == 0; ok = (m_n[0] == 6); end
      4: v = (2 * m_cnt[1]) < m_n[1] - (m_n[1] % 2);
      5: begin v = (m_cnt[1] % 2) == 0; ok = (m_n[1] % 4) == 0; end
      6: begin v = (m_cnt[1] % 4) < 2; ok = (m_n[1] % 8) == 0; end
      default: v = 1'b0;
    endcase
  endtask

  task automatic cyc(input string tag);
    int nn[2], nc[2], np[2], ns[6];
    bit npk[2], v, ok, we, trm;
    bit [5:0] no, ne;
    bit [1:0] nr;
    int val;
    if (rst) begin
      for (int b = 0; b < 2; b++) begin
        nn[b] = 8; nc[b] = 0; np[b] = 8; npk[b] = 1'b1;
      end
      for (int i = 0; i < 6; i++) ns[i] = 0;
      no = '0; ne = '0; nr = '0;
    end else begin
      for (int i = 0; i < 6; i++) begin
        src_eval(m_sel[i], v, ok);
        no[i] = v && ok;
        ne[i] = m_err[i] || !ok;
        ns[i] = (sel_we && int'(sel_idx) == i) ? int'(sel_code) : m_sel[i];
      end
      for (int b = 0; b < 2; b++) begin
        we  = (b == 0) ? na_we : nb_we;
        val = (b == 0) ? int'(na_val) : int'(nb_val);
        trm = (m_cnt[b] == m_n[b] - 1);
        nc[b] = trm ? 0 : m_cnt[b] + 1;
        nn[b] = (trm && m_pok[b]) ? m_pend[b] : m_n[b];
        np[b] = we ? val : m_pend[b];
        npk[b] = we ? (val >= 4 && val <= 127) : m_pok[b];
        nr[b] = !npk[b];
      end
    end
    @(posedge clk);
    @(negedge clk);
    m_n = nn; m_cnt = nc; m_pend = np; m_pok = npk; m_sel = ns;
    m_out = no; m_err = ne; m_rerr = nr;
    na_we = 1'b0; nb_we = 1'b0; sel_we = 1'b0;
    check(clk_out == m_out, tag, "clk_out", int'(clk_out), int'(m_out));
    check(out_err == m_err, tag, "out_err", int'(out_err), int'(m_err));
    check(n_err == m_rerr, tag, "n_err", int'(n_err), int'(m_rerr));
  endtask

  task automatic set_sel(input int idx, input int code, input string tag);
    sel_we = 1'b1; sel_idx = 3'(idx); sel_code = 3'(code);
    cyc(tag);
  endtask

  task automatic do_reset();
    rst = 1'b1; cyc("R2"); rst = 1'b0;
  endtask

  task automatic high_count(input int n, input string tag);
    int hi = 0;
    do_reset();
    set_sel(0, 1, tag);
    na_we = 1'b1; na_val = 7'(n);
    cyc(tag);
    for (int k = 0; k < 2 * n + 10; k++) cyc(tag);
    for (int k = 0; k < n; k++) begin
      cyc(tag);
      hi += int'(clk_out[0]);
    end
    check(hi == n / 2, tag, "high cycles per period", hi, n / 2);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R2: reset state
    rst = 1'b1;
    cyc("R2"); cyc("R2");
    check(clk_out == 6'd0 && out_err == 6'd0 && n_err == 2'd0, "R2", "reset outputs",
          int'({clk_out, out_err, n_err}), 0);
    rst = 1'b0;
    // R5: reference bypass after reset is constant high
    for (int k = 0; k < 3; k++) cyc("R5");
    check(clk_out == 6'h3f, "R5", "bypass all high", int'(clk_out), 63);

    // R4 R6 R8 R9: sweep bank A over every legal N, bank B mirrored
    for (int n = 4; n <= 127; n++) begin
      int nb = 131 - n;
      int span = 2 * ((n > nb) ? n : nb) + 12;
      do_reset();
      for (int i = 0; i < 6; i++) set_sel(i, i + 1, "R9");
      set_sel(6, 7, "R9");   // index 6 ignored
      na_we = 1'b1; na_val = 7'(n); nb_we = 1'b1; nb_val = 7'(nb);
      cyc("R8");
      for (int k = 0; k < span; k++) cyc("R4 R6");
    end

    // R4: explicit high-phase counts
    high_count(7, "R4");
    high_count(9, "R4");
    high_count(10, "R4");

    // R3: mid-period write of a smaller N must not cut the running period
    do_reset();
    set_sel(0, 1, "R3");
    na_we = 1'b1; na_val = 7'd20; cyc("R3");
    for (int k = 0; k < 40; k++) cyc("R3");
    na_we = 1'b1; na_val = 7'd5; cyc("R3");
    for (int k = 0; k < 40; k++) cyc("R3");

    // R1: out-of-range writes flagged and never loaded
    na_we = 1'b1; na_val = 7'd3; cyc("R1");
    check(n_err == 2'b01, "R1", "n_err after 3", int'(n_err), 1);
    for (int k = 0; k < 15; k++) cyc("R1");
    nb_we = 1'b1; nb_val = 7'd0; cyc("R1");
    check(n_err == 2'b11, "R1", "n_err after 0", int'(n_err), 3);
    for (int k = 0; k < 15; k++) cyc("R1");
    na_we = 1'b1; na_val = 7'd127; nb_we = 1'b1; nb_val = 7'd4; cyc("R1");
    check(n_err == 2'b00, "R1", "n_err cleared", int'(n_err), 0);
    for (int k = 0; k < 260; k++) cyc("R1");

    // R7: illegal tap, then move away; error stays
    do_reset();
    na_we = 1'b1; na_val = 7'd6; cyc("R7");
    for (int k = 0; k < 10; k++) cyc("R7");
    set_sel(1, 2, "R7");
    for (int k = 0; k < 4; k++) cyc("R7");
    check(out_err[1] == 1'b1 && clk_out[1] == 1'b0, "R7", "illegal tap",
          int'({out_err[1], clk_out[1]}), 2);
    set_sel(1, 0, "R7");
    for (int k = 0; k < 4; k++) cyc("R7");
    check(out_err[1] == 1'b1 && clk_out[1] == 1'b1, "R7", "sticky after reselect",
          int'({out_err[1], clk_out[1]}), 3);
    set_sel(2, 3, "R6");   // /3 legal with N = 6
    for (int k = 0; k < 12; k++) cyc("R6");
    check(out_err[2] == 1'b0, "R6", "/3 legal at N=6", int'(out_err[2]), 0);

    // R5: code 7 drives low without error
    set_sel(3, 7, "R5");
    for (int k = 0; k < 5; k++) cyc("R5");
    check(clk_out[3] == 1'b0 && out_err[3] == 1'b0, "R5", "code 7 low",
          int'({out_err[3], clk_out[3]}), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule